// File: doc/BRIEF.md
# Oversampled Bitslip Comma Aligner

This block sits behind a lane deserializer that delivers each data bit as two consecutive raw samples. Every clock it accepts one parallel group of raw samples, keeps a short history of them, and rebuilds a 10-bit line character from every second sample, starting at a selectable sample offset. Because a character spans two clocks of raw samples, a new aligned character appears every other cycle.

Software aligns the lane by stepping the boundary. A one-cycle `bitslip_i` pulse moves the boundary by one raw sample, so one data bit needs two pulses. The sample offset covers one clock's worth of samples; the `wordslip_i` level selects which of the two cycles of a character period is used, extending the reach to a full character. After each step, software pulses `comma_rst_i` to clear and re-arm the comma detector, waits, and reads `comma_found_o`. The detector decides within a few cycles of re-arming, well inside the software's waiting time of about 100 µs. Up to ten double steps per attempt cover every position.

Top module: `cma_aligner`

## Requirements
- R1: While `rst_ni` is low, `word_o` is all zeros and `word_valid_o` and `comma_found_o` are low.
- R2: With `wordslip_i` held steady, `word_valid_o` is high on exactly every other cycle; toggling `wordslip_i` moves character capture to the other cycle of the pair, a shift of one clock's worth of raw samples.
- R3: Each cycle with `bitslip_i` high advances the sample offset by one, wrapping from CHAR_W-1 to 0. The alignment position `offset + CHAR_W*wordslip_i` spans 2*CHAR_W raw samples, one full character. Because each bit is two samples, a comma is found at exactly two adjacent positions (cyclically), and delaying the stream by one sample moves those positions up by one.
- R4: `word_o` is built from every other raw sample from the offset on. The earliest sample is in `word_o[CHAR_W-1]`, and within `raw_i` the earliest sample is bit CHAR_W-1. At an aligned position, the emitted words are the transmitted characters.
- R5: A valid word equal to 10'b0011111010 or 10'b1100000101 (MSB first) sets `comma_found_o` on the following cycle. No other word sets it.
- R6: `comma_found_o` stays high until a `comma_rst_i` cycle clears it on the next cycle. The clear wins over a detection in the same cycle.
- R7: A comma word presented while `bitslip_i` is high is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| raw_i | input | CHAR_W | Raw 2x-oversampled samples for this cycle, earliest in the MSB |
| bitslip_i | input | 1 | Advance the boundary by one raw sample (one cycle pulse) |
| wordslip_i | input | 1 | Selects which cycle of the two-cycle character period is captured |
| comma_rst_i | input | 1 | Clear and re-arm the comma detector |
| word_o | output | CHAR_W | Aligned character, first bit in the MSB |
| word_valid_o | output | 1 | `word_o` holds a newly captured character |
| comma_found_o | output | 1 | Sticky: a comma was captured since the last re-arm |

## Verification
On every cycle, the assertions check the offset stepping and wrap, the alternation of `word_valid_o`, and the flag rules. Those rules are that the flag only rises after a valid comma word without a slip, stays set until re-armed, clears after a re-arm, and is not set by a slip-cycle comma. Only the bench's sweeps can show that the sample selection is correct. Each bench sweep delays the stream by each of 20 sample phases, with both comma polarities, visits all 20 alignment positions, and confirms that exactly two adjacent positions find the comma, that the positions follow the delay, and that the words emitted there are the transmitted characters.

// File: rtl/cma_pkg.sv
package cma_pkg;
  localparam int unsigned CHAR_W_DEF = 10;
  localparam logic [9:0] K_NEG = 10'b0011111010;
  localparam logic [9:0] K_POS = 10'b1100000101;
endpackage

// File: rtl/cma_slip_ctrl.sv
module cma_slip_ctrl #(
  parameter int unsigned RAW_W = 10,
  localparam int unsigned OFF_W = $clog2(RAW_W)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             bitslip_i,
  input  logic             wordslip_i,
  output logic [OFF_W-1:0] off_o,
  output logic             cap_o
);
  logic [OFF_W-1:0] off_q;
  logic             ph_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      off_q <= '0;
      ph_q  <= 1'b0;
    end else begin
      ph_q <= ~ph_q;
      if (bitslip_i) begin
        if (off_q == OFF_W'(RAW_W - 1)) off_q <= '0;
        else                            off_q <= off_q + 1'b1;
      end
    end
  end

  assign off_o = off_q;
  // capture on the half of the character period picked by wordslip
  assign cap_o = (ph_q == wordslip_i);
endmodule

// File: rtl/cma_window.sv
module cma_window #(
  parameter int unsigned CHAR_W = 10,
  parameter int unsigned RAW_W  = 10,
  localparam int unsigned OFF_W  = $clog2(RAW_W),
  localparam int unsigned HIST_W = RAW_W + 2 * CHAR_W - 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [RAW_W-1:0]  raw_i,
  input  logic [OFF_W-1:0]  off_i,
  input  logic              cap_i,
  output logic [CHAR_W-1:0] word_o,
  output logic              valid_o
);
  logic [HIST_W-1:0] hist_q;
  logic [CHAR_W-1:0] dec;
  logic [CHAR_W-1:0] word_q;
  logic              valid_q;

  // MSB of hist_q is the oldest sample
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) hist_q <= '0;
    else         hist_q <= {hist_q[HIST_W-RAW_W-1:0], raw_i};
  end

  // keep every second sample from the offset on
  for (genvar j = 0; j < CHAR_W; j++) begin : g_dec
    always_comb dec[CHAR_W-1-j] = hist_q[HIST_W - 1 - 2 * j - int'(off_i)];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      word_q  <= '0;
      valid_q <= 1'b0;
    end else begin
      valid_q <= cap_i;
      if (cap_i) word_q <= dec;
    end
  end

  assign word_o  = word_q;
  assign valid_o = valid_q;
endmodule

// File: rtl/cma_detect.sv
module cma_detect #(
  parameter int unsigned       CHAR_W  = 10,
  parameter logic [CHAR_W-1:0] COMMA_A = cma_pkg::K_NEG,
  parameter logic [CHAR_W-1:0] COMMA_B = cma_pkg::K_POS
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [CHAR_W-1:0] word_i,
  input  logic              valid_i,
  input  logic              bitslip_i,
  input  logic              comma_rst_i,
  output logic              found_o
);
  logic hit;
  logic found_q;

  assign hit = valid_i && !bitslip_i && (word_i == COMMA_A || word_i == COMMA_B);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          found_q <= 1'b0;
    else if (comma_rst_i) found_q <= 1'b0;
    else if (hit)         found_q <= 1'b1;
  end

  assign found_o = found_q;
endmodule

// File: rtl/cma_aligner.sv
module cma_aligner #(
  parameter int unsigned       CHAR_W  = cma_pkg::CHAR_W_DEF,
  parameter logic [CHAR_W-1:0] COMMA_A = cma_pkg::K_NEG,
  parameter logic [CHAR_W-1:0] COMMA_B = cma_pkg::K_POS
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [CHAR_W-1:0] raw_i,
  input  logic              bitslip_i,
  input  logic              wordslip_i,
  input  logic              comma_rst_i,
  output logic [CHAR_W-1:0] word_o,
  output logic              word_valid_o,
  output logic              comma_found_o
);
  localparam int unsigned RAW_W = CHAR_W;  // 2x oversampling: one character per two cycles
  localparam int unsigned OFF_W = $clog2(RAW_W);

  logic [OFF_W-1:0] slip_off;
  logic             cap;

  cma_slip_ctrl #(.RAW_W(RAW_W)) u_ctrl (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .bitslip_i (bitslip_i),
    .wordslip_i(wordslip_i),
    .off_o     (slip_off),
    .cap_o     (cap)
  );

  cma_window #(.CHAR_W(CHAR_W), .RAW_W(RAW_W)) u_win (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .raw_i  (raw_i),
    .off_i  (slip_off),
    .cap_i  (cap),
    .word_o (word_o),
    .valid_o(word_valid_o)
  );

  cma_detect #(.CHAR_W(CHAR_W), .COMMA_A(COMMA_A), .COMMA_B(COMMA_B)) u_det (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .word_i     (word_o),
    .valid_i    (word_valid_o),
    .bitslip_i  (bitslip_i),
    .comma_rst_i(comma_rst_i),
    .found_o    (comma_found_o)
  );
endmodule

// File: rtl/cma_aligner_chk.sv
module cma_aligner_chk #(
  parameter int unsigned       CHAR_W  = 10,
  parameter logic [CHAR_W-1:0] COMMA_A = cma_pkg::K_NEG,
  parameter logic [CHAR_W-1:0] COMMA_B = cma_pkg::K_POS,
  localparam int unsigned      OFF_W   = $clog2(CHAR_W)
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              bitslip_i,
  input logic              wordslip_i,
  input logic              comma_rst_i,
  input logic [CHAR_W-1:0] word_o,
  input logic              word_valid_o,
  input logic              comma_found_o,
  input logic [OFF_W-1:0]  off_i
);
  always @(posedge clk_i) begin
    if (!rst_ni) begin
      p_reset_state_r1: assert (word_o == '0 && !word_valid_o && !comma_found_o);
    end
  end

  p_valid_alt_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    word_valid_o |=> (!word_valid_o || ($past(wordslip_i) != $past(wordslip_i, 2))));

  p_off_range_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    off_i <= OFF_W'(CHAR_W - 1));

  p_slip_step_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bitslip_i |=> off_i == (($past(off_i) == OFF_W'(CHAR_W - 1)) ? '0 : $past(off_i) + 1'b1));

  p_hold_off_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bitslip_i |=> $stable(off_i));

  p_set_cause_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(comma_found_o) |->
      $past(word_valid_o && !bitslip_i && !comma_rst_i && (word_o == COMMA_A || word_o == COMMA_B)));

  p_sticky_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (comma_found_o && !comma_rst_i) |=> comma_found_o);

  p_clear_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    comma_rst_i |=> !comma_found_o);

  p_slip_ignore_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bitslip_i && !comma_found_o) |=> !comma_found_o);
endmodule

bind cma_aligner cma_aligner_chk #(.CHAR_W(CHAR_W), .COMMA_A(COMMA_A), .COMMA_B(COMMA_B)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .bitslip_i    (bitslip_i),
  .wordslip_i   (wordslip_i),
  .comma_rst_i  (comma_rst_i),
  .word_o       (word_o),
  .word_valid_o (word_valid_o),
  .comma_found_o(comma_found_o),
  .off_i        (slip_off)
);

// File: tb/sim_cma_aligner.sv
`timescale 1ns/1ps
module sim_cma_aligner;
  localparam int W = 10;
  localparam int NPOS = 2 * W;

  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b1;
  logic [W-1:0] raw_i = '0;
  logic         bitslip_i = 1'b0;
  logic         wordslip_i = 1'b0;
  logic         comma_rst_i = 1'b0;
  logic [W-1:0] word_o;
  logic         word_valid_o;
  logic         comma_found_o;

  cma_aligner u0 (.*);

  always #4 clk_i = ~clk_i;

  int n_chk = 0;
  int n_err = 0;
  int tcnt = 0;
  int s0 = 0;
  int cur_off = 0;
  logic [19:0] pat = {10'b0011111010, 10'b0101010101};

  function automatic logic samp(int t);
    int k;
    k = (t - s0 + 800) / 2;
    return pat[19 - (k % 20)];
  endfunction

  always @(negedge clk_i) begin
    for (int i = 0; i < W; i++) raw_i[W-1-i] <= samp(tcnt * W + i);
    tcnt <= tcnt + 1;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk_i);
  endtask

  task automatic slip_to(input int target);
    while (cur_off != target) begin
      bitslip_i = 1'b1;
      tick();
      bitslip_i = 1'b0;
      cur_off = (cur_off + 1) % W;
    end
  endtask

  task automatic rearm();
    comma_rst_i = 1'b1;
    tick();
    comma_rst_i = 1'b0;
  endtask

  task automatic measure(input int p, output bit f);
    wordslip_i = (p >= W);
    slip_to(p % W);
    repeat (5) tick();
    rearm();
    repeat (8) tick();
    f = comma_found_o;
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    n_err++;
    n_chk++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    bit h[NPOS];
    bit f;
    int hits, p0, prev_p0, nval, dbl;
    bit last_v, seen_c, bad_w;
    #2 rst_ni = 1'b0;
    repeat (4) tick();
    // R1 reset state
    check(word_o == '0, "R1 word", int'(word_o), 0);
    check(!word_valid_o && !comma_found_o, "R1 flags", int'({word_valid_o, comma_found_o}), 0);
    rst_ni = 1'b1;
    repeat (4) tick();

    // R2 valid alternation with steady wordslip
    nval = 0; dbl = 0; last_v = 0;
    for (int c = 0; c < 20; c++) begin
      tick();
      if (word_valid_o) nval++;
      if (word_valid_o && last_v) dbl++;
      last_v = word_valid_o;
    end
    check(nval == 10, "R2 valid count", nval, 10);
    check(dbl == 0, "R2 back-to-back valid", dbl, 0);

    prev_p0 = 0;
    for (int sel = 0; sel < 2; sel++) begin
      pat = sel ? {10'b1100000101, 10'b1010101010} : {10'b0011111010, 10'b0101010101};
      for (int s = 0; s < NPOS; s++) begin
        s0 = s;
        for (int p = 0; p < NPOS; p++) begin
          measure(p, f);
          h[p] = f;
          if (f) begin
            // R4/R5: words at an aligned position are the sent characters
            seen_c = 0; bad_w = 0;
            for (int c = 0; c < 6; c++) begin
              tick();
              if (word_valid_o) begin
                if (word_o == pat[19:10]) seen_c = 1;
                else if (word_o != pat[9:0]) bad_w = 1;
              end
            end
            check(seen_c && !bad_w, "R4 aligned words", int'({seen_c, bad_w}), 2);
          end
        end
        hits = 0; p0 = -1;
        for (int p = 0; p < NPOS; p++) begin
          if (h[p]) hits++;
          if (h[p] && h[(p + 1) % NPOS]) p0 = p;
        end
        check(hits == 2, "R5 hit count", hits, 2);
        check(p0 >= 0, "R3 adjacent hits", p0, 0);
        if (s > 0) check(p0 == (prev_p0 + 1) % NPOS, "R3 position follows delay", p0, (prev_p0 + 1) % NPOS);
        prev_p0 = p0;
      end
    end

    // R6 sticky: find at prev_p0, then misalign without re-arm
    measure(prev_p0, f);
    check(f, "R6 found before misalign", int'(f), 1);
    s0 = (s0 + 7) % NPOS;
    repeat (12) tick();
    check(comma_found_o, "R6 sticky", int'(comma_found_o), 1);
    rearm();
    repeat (8) tick();
    check(!comma_found_o, "R6 cleared by re-arm", int'(comma_found_o), 0);

    // R7 commas during slip cycles are ignored
    s0 = (s0 + NPOS - 7) % NPOS;
    repeat (6) tick();
    comma_rst_i = 1'b1;
    bitslip_i = 1'b1;
    tick();
    comma_rst_i = 1'b0;
    f = 0;
    for (int c = 0; c < 2 * W - 1; c++) begin
      tick();
      if (comma_found_o) f = 1;
    end
    bitslip_i = 1'b0;
    check(!f, "R7 slip-cycle comma ignored", int'(f), 0);
    repeat (8) tick();
    check(comma_found_o, "R7 found after slips stop", int'(comma_found_o), 1);

    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule